// File: doc/BRIEF.md
# Self-Test Sequencer With Sample-Period Restore

This block runs a built-in diagnostic routine for a sensor front end. When reset is released, it starts one test pass by itself, unless a retained skip setting tells it not to. Software can also set a continuous-test bit, and the block then repeats passes back to back until the bit is cleared. Each pass lasts a fixed number of clock cycles. A mode input chooses between a shorter length for high-performance operation and a longer length for low-power operation.

While a pass runs, the block asserts a stimulus-enable output that drives the mechanical excitation. It also replaces the user's sample-period setting with a fast period so the test completes sooner. The user's value is kept in a shadow copy. Writes made during the test go into that copy, and the copy becomes visible again the cycle after the test ends.

Every measurement result that arrives during a pass is compared against an expected value with a programmable tolerance. The pass fails if any result lies outside the window, or if no result arrives at all. The verdict of the latest completed pass is shown as one bit of a status byte.

Top module: `stest_seq`

## Requirements
- R1: While reset is low, `boot_q` is 1. On the first clock edge after reset is released, a pass starts if `nv_skip_i` is 0, and `busy_o` reads 1 after that edge. If `nv_skip_i` is 1, no pass starts at that point.
- R2: A pass runs for exactly `DUR_HP` cycles (13 by default) when `mode_i` is 0 at its start edge, and for exactly `DUR_LP` cycles (35 by default) when `mode_i` is 1. `test_done_o` is high only in the last busy cycle of a pass.
- R3: While `busy_o` is 1, `stim_o` is 1 and `period_o` equals `FAST_PERIOD` (1). When the block is idle, `stim_o` is 0.
- R4: A write on `ctl_wdata_i` with `ctl_we_i` high loads the continuous bit from bit 8. All other bits have no effect. When the continuous bit is set and the block is idle, a pass starts. When the bit is set at the end of a pass, the next pass starts with no idle cycle. When the bit is cleared during a pass, that pass completes and the block then goes idle.
- R5: A sample-period write updates the shadow copy, which resets to `PERIOD_RST` (10). `period_o` shows the shadow copy whenever the block is idle. When the write is made while idle, `period_o` shows the new value the next cycle. When it is made during a pass, `period_o` shows it once the pass ends.
- R6: A pass fails if any valid result during it differs from `meas_exp_i` by more than `meas_tol_i`, or if it receives no valid result. A difference exactly equal to the tolerance passes.
- R7: `status_o[5]` holds the verdict of the last completed pass, with 1 meaning fail. It changes only on the edge that ends a pass and is 0 after reset. All other `status_o` bits read 0.
- R8: Reset clears the continuous bit. After reset with `nv_skip_i` at 1, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nv_skip_i | input | 1 | Retained setting that skips the pass after reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 16 | Control word; bit 8 is the continuous-test bit |
| per_we_i | input | 1 | Sample-period write strobe |
| per_wdata_i | input | PW | Sample-period write value |
| mode_i | input | 1 | 0 selects the high-performance pass length, 1 the low-power length |
| meas_valid_i | input | 1 | A measurement result is present |
| meas_i | input | MW | Measurement result |
| meas_exp_i | input | MW | Expected measurement under stimulus |
| meas_tol_i | input | MW | Allowed absolute deviation |
| period_o | output | PW | Effective sample period |
| stim_o | output | 1 | Stimulus enable |
| busy_o | output | 1 | A pass is running |
| test_done_o | output | 1 | Last cycle of a pass |
| status_o | output | 8 | Status byte; bit 5 is the fail flag |

## Verification
Passes are run in which every sample is close to the expected value, every sample is beyond the tolerance, every sample sits exactly at the tolerance, one sample is wrong among good ones, and no sample arrives. Together these show whether the window is a strict or inclusive comparison, whether it is applied to every sample or only the last one, and how a missing sample is handled. The boot pass, single passes started by software in both length modes, and a continuous pair separate the three ways a pass can start. They also show whether the length is taken from `mode_i` and whether back-to-back passes leave a gap. A period write made during the boot pass, compared with one made while idle, shows whether the shadow copy is captured and restored.

// File: rtl/stest_pkg.sv
package stest_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_state_e;
  localparam int unsigned CTL_CONT_BIT  = 8;
  localparam int unsigned STAT_FAIL_BIT = 5;
  localparam int unsigned STAT_W        = 8;
endpackage

// File: rtl/stest_timer.sv
module stest_timer #(
  parameter int unsigned DUR_HP = 13,
  parameter int unsigned DUR_LP = 35,
  parameter int unsigned CW     = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic mode_i,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned DMAX = (DUR_HP > DUR_LP) ? DUR_HP : DUR_LP;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= mode_i ? CW'(DUR_LP - 1) : CW'(DUR_HP - 1);
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = run_i && (cnt_q == '0);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DMAX - 1));
  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/stest_window.sv
module stest_window #(
  parameter int unsigned MW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          valid_i,
  input  logic [MW-1:0] meas_i,
  input  logic [MW-1:0] exp_i,
  input  logic [MW-1:0] tol_i,
  output logic          fail_o
);
  logic [MW-1:0] diff;
  logic          take, bad_now;
  logic          bad_q, seen_q;

  assign diff    = (meas_i >= exp_i) ? (meas_i - exp_i) : (exp_i - meas_i);
  assign take    = run_i && valid_i;
  assign bad_now = take && (diff > tol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (clear_i) begin
      bad_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (take) begin
      bad_q  <= bad_q | bad_now;
      seen_q <= 1'b1;
    end
  end

  // verdict includes the sample arriving on the closing cycle
  assign fail_o = bad_q | bad_now | ~(seen_q | take);

  p_bad_needs_seen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_q |-> seen_q);
  p_no_sample_fails_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !take) |-> fail_o);
endmodule

// File: rtl/stest_period.sv
module stest_period #(
  parameter int unsigned PW          = 16,
  parameter int unsigned FAST_PERIOD = 1,
  parameter int unsigned PERIOD_RST  = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] wdata_i,
  input  logic          run_i,
  output logic [PW-1:0] per_o
);
  logic [PW-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= PW'(PERIOD_RST);
    else if (we_i) shadow_q <= wdata_i;
  end

  assign per_o = run_i ? PW'(FAST_PERIOD) : shadow_q;

  p_idle_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (run_i || per_o == $past(wdata_i)));
endmodule

// File: rtl/stest_seq.sv
module stest_seq #(
  parameter int unsigned PW          = 16,
  parameter int unsigned MW          = 12,
  parameter int unsigned DUR_HP      = 13,
  parameter int unsigned DUR_LP      = 35,
  parameter int unsigned FAST_PERIOD = 1,
  parameter int unsigned PERIOD_RST  = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nv_skip_i,
  input  logic          ctl_we_i,
  input  logic [15:0]   ctl_wdata_i,
  input  logic          per_we_i,
  input  logic [PW-1:0] per_wdata_i,
  input  logic          mode_i,
  input  logic          meas_valid_i,
  input  logic [MW-1:0] meas_i,
  input  logic [MW-1:0] meas_exp_i,
  input  logic [MW-1:0] meas_tol_i,
  output logic [PW-1:0] period_o,
  output logic          stim_o,
  output logic          busy_o,
  output logic          test_done_o,
  output logic [7:0]    status_o
);
  import stest_pkg::*;

  localparam int unsigned DMAX = (DUR_HP > DUR_LP) ? DUR_HP : DUR_LP;
  localparam int unsigned CW   = $clog2(DMAX + 1);

  st_state_e state_q, state_d;
  logic      boot_q, cont_q, fail_q;
  logic      run, last, start_idle, restart, load, verdict;
  logic      unused_ctl;

  assign unused_ctl = ^{ctl_wdata_i[15:CTL_CONT_BIT+1], ctl_wdata_i[CTL_CONT_BIT-1:0]};

  assign run        = (state_q == ST_RUN);
  assign start_idle = !run && ((boot_q && !nv_skip_i) || cont_q);
  assign restart    = last && cont_q;
  assign load       = start_idle || restart;

  always_comb begin
    state_d = state_q;
    if (start_idle) state_d = ST_RUN;
    else if (last && !cont_q) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      boot_q  <= 1'b1;
      cont_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      boot_q  <= 1'b0;
      if (ctl_we_i) cont_q <= ctl_wdata_i[CTL_CONT_BIT];
      if (last) fail_q <= verdict;
    end
  end

  stest_timer #(.DUR_HP(DUR_HP), .DUR_LP(DUR_LP), .CW(CW)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load), .mode_i(mode_i),
    .run_i (run), .last_o(last)
  );

  stest_window #(.MW(MW)) u_window (
    .clk_i (clk_i), .rst_ni(rst_ni), .clear_i(load), .run_i(run),
    .valid_i(meas_valid_i), .meas_i(meas_i), .exp_i(meas_exp_i),
    .tol_i (meas_tol_i), .fail_o(verdict)
  );

  stest_period #(.PW(PW), .FAST_PERIOD(FAST_PERIOD), .PERIOD_RST(PERIOD_RST)) u_period (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(per_we_i), .wdata_i(per_wdata_i),
    .run_i (run), .per_o(period_o)
  );

  assign busy_o      = run;
  assign stim_o      = run;
  assign test_done_o = last;

  always_comb begin
    status_o                = '0;
    status_o[STAT_FAIL_BIT] = fail_q;
  end

  p_fast_while_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (stim_o && period_o == PW'(FAST_PERIOD)));
  p_cont_rerun_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_done_o && cont_q) |=> busy_o);
  p_stop_after_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_done_o && !cont_q) |=> !busy_o);
  p_status_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_done_o |=> $stable(status_o));
  p_boot_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_q && !nv_skip_i) |=> busy_o);
endmodule

// File: tb/stest_seq_bench.sv
module stest_seq_bench;
  localparam int D_HP = 13;
  localparam int D_LP = 35;
  localparam int FAST = 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        nv_skip_i = 1'b1;
  logic        ctl_we_i = 1'b0;
  logic [15:0] ctl_wdata_i = '0;
  logic        per_we_i = 1'b0;
  logic [15:0] per_wdata_i = '0;
  logic        mode_i = 1'b0;
  logic        meas_valid_i = 1'b0;
  logic [11:0] meas_i = '0;
  logic [11:0] meas_exp_i = 12'd100;
  logic [11:0] meas_tol_i = 12'd4;
  logic [15:0] period_o;
  logic        stim_o, busy_o, test_done_o;
  logic [7:0]  status_o;

  int  n_run = 0, n_fail = 0;
  bit  exp_q[$];
  bit  done_d = 1'b0;
  bit  finished = 1'b0;
  int  glitch_at = -1;
  logic [11:0] meas_good = 12'd100;

  always #5 clk_i = ~clk_i;

  stest_seq u_stest_seq (.*);

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // monitor: verdict appears the cycle after test_done_o
  always @(negedge clk_i) begin
    if (!rst_ni) done_d = 1'b0;
    else begin
      if (done_d) begin
        if (exp_q.size() == 0) check("R7 unexpected verdict", 1'b0, status_o[5], -1);
        else begin
          bit e;
          e = exp_q.pop_front();
          check("R6/R7 verdict", status_o[5] == e, status_o[5], e);
          check("R7 other bits zero", (status_o & 8'hDF) == 8'h00, status_o, 0);
        end
      end
      done_d = test_done_o;
    end
  end

  // counts consecutive busy cycles, checks stimulus and period, optional writes
  task automatic observe(input int dlen, input int pwr_at, input logic [15:0] pval,
                         input int cwr_at, input string tag);
    int  n = 0;
    bit  r3_ok = 1'b1;
    @(negedge clk_i);
    ctl_we_i = 1'b0; per_we_i = 1'b0;
    while (busy_o && n < 200) begin
      if (!stim_o || period_o != 16'(FAST)) r3_ok = 1'b0;
      meas_i = (n == glitch_at) ? 12'd300 : meas_good;
      if (n == pwr_at) begin per_we_i = 1'b1; per_wdata_i = pval; end
      if (n == cwr_at) begin ctl_we_i = 1'b1; ctl_wdata_i = 16'h0000; end
      n++;
      @(negedge clk_i);
      ctl_we_i = 1'b0; per_we_i = 1'b0;
    end
    meas_i = meas_good;
    check({"R3 stim/fast period ", tag}, r3_ok, r3_ok, 1);
    check({"R2 duration ", tag}, n == dlen, n, dlen);
    check({"R3 stim low idle ", tag}, stim_o == 1'b0, stim_o, 0);
  endtask

  task automatic single_pass(input bit md, input bit expect_fail, input string tag);
    mode_i = md;
    exp_q.push_back(expect_fail);
    @(negedge clk_i); ctl_we_i = 1'b1; ctl_wdata_i = 16'h0100;
    @(negedge clk_i); ctl_we_i = 1'b1; ctl_wdata_i = 16'h0000;
    observe(md ? D_LP : D_HP, -1, '0, -1, tag);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic do_reset(input bit skip);
    @(negedge clk_i);
    rst_ni = 1'b0; nv_skip_i = skip;
    ctl_we_i = 1'b0; per_we_i = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    int idle_cnt;
    // R1 / R8 reset state, skip set
    repeat (3) @(negedge clk_i);
    check("R7 status after reset", status_o == 8'h00, status_o, 0);
    check("R5 reset period", period_o == 16'd10, period_o, 10);
    rst_ni = 1'b1;
    idle_cnt = 0;
    repeat (5) begin @(negedge clk_i); if (busy_o) idle_cnt++; end
    check("R1 skip keeps idle", idle_cnt == 0, idle_cnt, 0);

    // R5 idle write
    per_we_i = 1'b1; per_wdata_i = 16'd20;
    @(negedge clk_i); per_we_i = 1'b0;
    check("R5 idle write visible", period_o == 16'd20, period_o, 20);

    // R1 boot pass, in-window samples, write during pass
    do_reset(1'b0);
    mode_i = 1'b0; meas_valid_i = 1'b1; meas_good = 12'd102; meas_i = 12'd102;
    exp_q.push_back(1'b0);
    rst_ni = 1'b1;
    observe(D_HP, 4, 16'd33, -1, "boot");
    check("R5 restored after pass", period_o == 16'd33, period_o, 33);

    // R6 out of window, long mode
    meas_good = 12'd105; single_pass(1'b1, 1'b1, "lp bad");
    // R6 exactly at tolerance
    meas_good = 12'd96;  single_pass(1'b0, 1'b0, "edge");
    // R6 one bad sample among good ones
    glitch_at = 6; meas_good = 12'd100; single_pass(1'b1, 1'b1, "glitch");
    glitch_at = -1;
    // R6 no samples
    meas_valid_i = 1'b0; single_pass(1'b0, 1'b1, "nosample");
    meas_valid_i = 1'b1;
    check("R3 idle period shadow", period_o == 16'd33, period_o, 33);

    // R4 ignored control bits
    @(negedge clk_i); ctl_we_i = 1'b1; ctl_wdata_i = 16'hFEFF;
    @(negedge clk_i); ctl_we_i = 1'b0;
    idle_cnt = 0;
    repeat (5) begin @(negedge clk_i); if (busy_o) idle_cnt++; end
    check("R4 other ctl bits ignored", idle_cnt == 0, idle_cnt, 0);

    // R4 continuous: two back-to-back passes, cleared in the second
    mode_i = 1'b0;
    exp_q.push_back(1'b0); exp_q.push_back(1'b0);
    @(negedge clk_i); ctl_we_i = 1'b1; ctl_wdata_i = 16'h0100;
    @(negedge clk_i); ctl_we_i = 1'b0;
    observe(2 * D_HP, -1, '0, D_HP + 2, "cont");
    repeat (2) @(negedge clk_i);

    // R8 reset clears continuous bit
    @(negedge clk_i); ctl_we_i = 1'b1; ctl_wdata_i = 16'h0100;
    @(negedge clk_i); ctl_we_i = 1'b0;
    repeat (4) @(negedge clk_i);
    do_reset(1'b1);
    rst_ni = 1'b1;
    idle_cnt = 0;
    repeat (40) begin @(negedge clk_i); if (busy_o) idle_cnt++; end
    check("R8 cont cleared by reset", idle_cnt == 0, idle_cnt, 0);
    check("R7 status cleared", status_o == 8'h00, status_o, 0);
    check("R5 period back to reset value", period_o == 16'd10, period_o, 10);
    check("R7 all verdicts consumed", exp_q.size() == 0, exp_q.size(), 0);

    finish_run();
  end

  initial begin
    #1000000;
    check("watchdog", 1'b0, 0, 1);
    finish_run();
  end
endmodule